// File: doc/BRIEF.md
# Two-Phase Microcode Sequencer

This block is the control unit of a microcoded datapath. It runs from one clock and divides every microcycle into two T-states. In T1 the decoded destination field of the current microinstruction drives single-cycle synchronous load enables, and the datapath captures its results. In T2 the sequencer registers the next microaddress and the microinstruction stored there, both on the edge that closes T2. The ALU operation field stays valid for the whole microcycle.

The next address is chosen in this order. A pending trap request comes first. After that, the sequencing mode of the current microinstruction decides: plain increment, a conditional branch on one selected flag, or an unconditional jump. The microcode store is a small table inside the block. The datapath and the ALU belong to the surrounding design.

Top module: `useq_two_phase`

## Requirements
- R1: The T-state alternates on every clock. The output `t1_o` is 1 in T1 and 0 in T2, and reset always leaves the block in T1.
- R2: The microaddress and the microinstruction change only on the clock edge that ends T2, and they change together. During a microcycle `uaddr_o` and `alu_op_o` hold steady.
- R3: Load enables are asserted only while `t1_o` is 1. Every load enable is therefore a single-cycle pulse in each microcycle.
- R4: A destination field of value k, from 1 to NDST-1, asserts `ld_en_o[k]` alone. A field of 0 asserts no enable, and `ld_en_o[0]` is never asserted.
- R5: `pc_ld_o` is asserted in T1 exactly when the destination field equals 3, the program-counter code.
- R6: The sequencing mode is a 2-bit code: 0 increments the address, 1 is a conditional branch, and 2 jumps to the target field. A conditional branch tests `cond_i[csel]`. It goes to the target when that flag is 1 and increments the address when it is 0.
- R7: `trap_req_i` is sampled only on the edge that ends T2. When it is set there, the next address is the trap vector (default 16), ahead of any branch or jump.
- R8: Synchronous reset sets T1, address 0 and no load enables. The microinstruction at address 0 is fetched at the end of that first microcycle.
- R9: The default program is defined as follows. Every microinstruction is listed as destination/ALU operation/sequencing. Address 0: 1/1/next. Address 1: 3/2/next. Address 2: 0/0/branch on flag 0 to 8. Address 3: 2/3/jump 0. Address 8: 4/5/branch on flag 2 to 12. Address 9: 5/6/jump 0. Address 12: 3/7/jump 0. Address 16: 6/8/jump 0. Every other address holds 0/0/next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | NCOND | Condition flags that conditional branches can test |
| trap_req_i | input | 1 | Trap or interrupt request, sampled at the end of T2 |
| ld_en_o | output | NDST | One-hot register load enables, active in T1 |
| pc_ld_o | output | 1 | Program-counter load enable |
| alu_op_o | output | ALU_W | ALU operation of the current microinstruction |
| uaddr_o | output | AW | Address of the current microinstruction |
| t1_o | output | 1 | High in T1, low in T2 |

## Verification
The hardest case to reach from the ports is the trap sampling window. A request that is raised in T1 and dropped before the edge that ends T2 must leave sequencing unchanged. To exercise this, the bench raises the request at the falling edge inside T1 and clears it at the falling edge inside T2. It also covers the case where a trap collides with a taken conditional branch, and the trap must win.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int UW_AW   = 5;
   localparam int UW_DST  = 3;
   localparam int UW_ALU  = 4;
   localparam int UW_CSEL = 2;

   typedef enum logic [1:0] {
      SEQ_NEXT = 2'd0,
      SEQ_COND = 2'd1,
      SEQ_JUMP = 2'd2,
      SEQ_RSVD = 2'd3
   } seq_mode_e;

   typedef struct packed {
      logic [UW_DST-1:0]  dst;
      logic [UW_ALU-1:0]  alu;
      seq_mode_e          mode;
      logic [UW_CSEL-1:0] csel;
      logic [UW_AW-1:0]   target;
   } uinst_t;

   function automatic uinst_t mk_uinst(input int d, input int a, input seq_mode_e m,
                                       input int c, input int t);
      uinst_t u;
      u.dst    = UW_DST'(d);
      u.alu    = UW_ALU'(a);
      u.mode   = m;
      u.csel   = UW_CSEL'(c);
      u.target = UW_AW'(t);
      return u;
   endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
   import useq_pkg::*;
#(
   parameter int AW = UW_AW
) (
   input  logic [AW-1:0] addr,
   output uinst_t        word
);
   always_comb begin
      case (addr)
         AW'(0):  word = mk_uinst(1, 1, SEQ_NEXT, 0, 0);
         AW'(1):  word = mk_uinst(3, 2, SEQ_NEXT, 0, 0);
         AW'(2):  word = mk_uinst(0, 0, SEQ_COND, 0, 8);
         AW'(3):  word = mk_uinst(2, 3, SEQ_JUMP, 0, 0);
         AW'(8):  word = mk_uinst(4, 5, SEQ_COND, 2, 12);
         AW'(9):  word = mk_uinst(5, 6, SEQ_JUMP, 0, 0);
         AW'(12): word = mk_uinst(3, 7, SEQ_JUMP, 0, 0);
         AW'(16): word = mk_uinst(6, 8, SEQ_JUMP, 0, 0);
         default: word = mk_uinst(0, 0, SEQ_NEXT, 0, 0);
      endcase
   end
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int AW       = UW_AW,
   parameter int NCOND    = 4,
   parameter int TRAP_VEC = 16
) (
   input  uinst_t            cur,
   input  logic [AW-1:0]     cur_addr,
   input  logic [NCOND-1:0]  cond_i,
   input  logic              trap_i,
   output logic [AW-1:0]     nxt
);
   logic flag_sel;

   generate
      if (NCOND == (1 << UW_CSEL)) begin : g_full_mux
         assign flag_sel = cond_i[cur.csel];
      end else begin : g_part_mux
         assign flag_sel = (int'(cur.csel) < NCOND) ? cond_i[cur.csel] : 1'b0;
      end
   endgenerate

   always_comb begin
      if (trap_i) begin
         nxt = AW'(TRAP_VEC);
      end else begin
         case (cur.mode)
            SEQ_COND: nxt = flag_sel ? cur.target : cur_addr + AW'(1);
            SEQ_JUMP: nxt = cur.target;
            default:  nxt = cur_addr + AW'(1);
         endcase
      end
   end
endmodule

// File: rtl/useq_strobe.sv
module useq_strobe
   import useq_pkg::*;
#(
   parameter int NDST = 1 << UW_DST
) (
   input  logic [UW_DST-1:0] dst,
   input  logic              t1,
   output logic [NDST-1:0]   ld_en
);
   assign ld_en[0] = 1'b0;
   generate
      for (genvar k = 1; k < NDST; k++) begin : g_dec
         assign ld_en[k] = t1 && (dst == UW_DST'(k));
      end
   endgenerate
endmodule

// File: rtl/useq_two_phase.sv
module useq_two_phase
   import useq_pkg::*;
#(
   parameter int AW       = UW_AW,
   parameter int NCOND    = 4,
   parameter int NDST     = 1 << UW_DST,
   parameter int ALU_W    = UW_ALU,
   parameter int PC_CODE  = 3,
   parameter int TRAP_VEC = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NCOND-1:0]  cond_i,
   input  logic              trap_req_i,
   output logic [NDST-1:0]   ld_en_o,
   output logic              pc_ld_o,
   output logic [ALU_W-1:0]  alu_op_o,
   output logic [AW-1:0]     uaddr_o,
   output logic              t1_o
);
   localparam uinst_t BUBBLE = mk_uinst(0, 0, SEQ_JUMP, 0, 0);

   generate
      if (AW != UW_AW) begin : g_chk_aw
         $error("AW must match the microinstruction target width");
      end
      if (ALU_W != UW_ALU) begin : g_chk_alu
         $error("ALU_W must match the microinstruction ALU field");
      end
      if (NDST != (1 << UW_DST)) begin : g_chk_dst
         $error("NDST must equal two to the destination field width");
      end
      if (NCOND < 1 || NCOND > (1 << UW_CSEL)) begin : g_chk_cond
         $error("NCOND out of range for the select field");
      end
      if (PC_CODE < 1 || PC_CODE >= NDST) begin : g_chk_pc
         $error("PC_CODE must be a nonzero destination code");
      end
      if (TRAP_VEC >= (1 << AW)) begin : g_chk_trap
         $error("TRAP_VEC outside the microcode address space");
      end
   endgenerate

   logic          t1_q;
   logic [AW-1:0] addr_q;
   uinst_t        ir_q;
   logic [AW-1:0] nxt_addr;
   uinst_t        rom_word;

   useq_next #(.AW(AW), .NCOND(NCOND), .TRAP_VEC(TRAP_VEC)) next_i (
      .cur      (ir_q),
      .cur_addr (addr_q),
      .cond_i   (cond_i),
      .trap_i   (trap_req_i),
      .nxt      (nxt_addr)
   );

   useq_rom #(.AW(AW)) rom_i (
      .addr (nxt_addr),
      .word (rom_word)
   );

   useq_strobe #(.NDST(NDST)) strobe_i (
      .dst   (ir_q.dst),
      .t1    (t1_q),
      .ld_en (ld_en_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         t1_q   <= 1'b1;
         addr_q <= '0;
         ir_q   <= BUBBLE;
      end else begin
         t1_q <= ~t1_q;
         if (!t1_q) begin
            addr_q <= nxt_addr;
            ir_q   <= rom_word;
         end
      end
   end

   assign pc_ld_o  = ld_en_o[PC_CODE];
   assign alu_op_o = ir_q.alu;
   assign uaddr_o  = addr_q;
   assign t1_o     = t1_q;
endmodule

// File: rtl/useq_two_phase_chk.sv
module useq_two_phase_chk #(
   parameter int AW       = 5,
   parameter int NDST     = 8,
   parameter int ALU_W    = 4,
   parameter int TRAP_VEC = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             trap_req_i,
   input logic [NDST-1:0]  ld_en_o,
   input logic             pc_ld_o,
   input logic [ALU_W-1:0] alu_op_o,
   input logic [AW-1:0]    uaddr_o,
   input logic             t1_o
);
   AST_PHASE_T1_TO_T2: assert property (@(posedge clk) disable iff (rst) t1_o |=> !t1_o); // R1
   AST_PHASE_T2_TO_T1: assert property (@(posedge clk) disable iff (rst) !t1_o |=> t1_o); // R1
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) t1_o |=> $stable(uaddr_o) && $stable(alu_op_o)); // R2
   AST_LOAD_ONLY_T1: assert property (@(posedge clk) disable iff (rst) !t1_o |-> ld_en_o == '0); // R3
   AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ld_en_o) && !ld_en_o[0]); // R4
   AST_PC_LOAD_T1: assert property (@(posedge clk) disable iff (rst) pc_ld_o |-> t1_o); // R5
   AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (rst) (!t1_o && trap_req_i) |=> uaddr_o == AW'(TRAP_VEC)); // R7
   AST_RESET_STATE: assert property (@(posedge clk) rst |=> t1_o && uaddr_o == '0 && ld_en_o == '0); // R8
endmodule

bind useq_two_phase useq_two_phase_chk #(
   .AW(AW), .NDST(NDST), .ALU_W(ALU_W), .TRAP_VEC(TRAP_VEC)
) chk_i (
   .clk(clk), .rst(rst), .trap_req_i(trap_req_i), .ld_en_o(ld_en_o),
   .pc_ld_o(pc_ld_o), .alu_op_o(alu_op_o), .uaddr_o(uaddr_o), .t1_o(t1_o)
);

// File: tb/useq_two_phase_tb_top.sv
`timescale 1ns/1ps
module useq_two_phase_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] cond_i = '0;
   logic       trap_req_i = 1'b0;
   logic [7:0] ld_en_o;
   logic       pc_ld_o;
   logic [3:0] alu_op_o;
   logic [4:0] uaddr_o;
   logic       t1_o;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   useq_two_phase dut_i (
      .clk(clk), .rst(rst), .cond_i(cond_i), .trap_req_i(trap_req_i),
      .ld_en_o(ld_en_o), .pc_ld_o(pc_ld_o), .alu_op_o(alu_op_o),
      .uaddr_o(uaddr_o), .t1_o(t1_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // T1 view of a microcycle: address, one-hot load, ALU field, PC load
   task automatic chk_mc(input string req, input int addr, input int dst, input int alu);
      int exp_ld;
      exp_ld = (dst == 0) ? 0 : (1 << dst);
      chk(req, "t1", int'(t1_o), 1);
      chk(req, "uaddr", int'(uaddr_o), addr);
      chk(req, "ld_en", int'(ld_en_o), exp_ld);
      chk(req, "alu_op", int'(alu_op_o), alu);
      chk(req, "pc_ld", int'(pc_ld_o), (dst == 3) ? 1 : 0);
   endtask

   // advance one microcycle; checks T2 quietness on the way (R1, R3)
   task automatic step();
      @(negedge clk);
      chk("R1", "t2 phase", int'(t1_o), 0);
      chk("R3", "no load in T2", int'(ld_en_o), 0);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cond_i = '0;
      trap_req_i = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk_mc("R8", 0, 0, 0);
      step();
      chk_mc("R8", 0, 1, 1);
   endtask

   task automatic t_sequential();
      do_reset();
      step(); chk_mc("R9", 0, 1, 1);
      step(); chk_mc("R5", 1, 3, 2);
      step(); chk_mc("R4", 2, 0, 0);
   endtask

   task automatic t_cond_taken();
      do_reset();
      step(); step(); step();
      cond_i = 4'b0001;
      step(); chk_mc("R6", 8, 4, 5);
      cond_i = 4'b0100;
      step(); chk_mc("R6", 12, 3, 7);
      cond_i = '0;
      step(); chk_mc("R6", 0, 1, 1);
   endtask

   task automatic t_cond_not_taken();
      do_reset();
      step(); step(); step();
      cond_i = 4'b1110;
      step(); chk_mc("R6", 3, 2, 3);
      step(); chk_mc("R6", 0, 1, 1);
      step(); step();
      cond_i = 4'b0001;
      step(); chk_mc("R6", 8, 4, 5);
      cond_i = 4'b1011;
      step(); chk_mc("R6", 9, 5, 6);
      cond_i = '0;
      step(); chk_mc("R6", 0, 1, 1);
   endtask

   task automatic t_trap();
      do_reset();
      step(); step();
      trap_req_i = 1'b1;
      step(); chk_mc("R7", 16, 6, 8);
      trap_req_i = 1'b0;
      step(); chk_mc("R7", 0, 1, 1);
      step(); step();
      cond_i = 4'b0001;
      trap_req_i = 1'b1;
      step(); chk_mc("R7", 16, 6, 8);
      trap_req_i = 1'b0;
      cond_i = '0;
   endtask

   task automatic t_trap_window();
      do_reset();
      step();
      trap_req_i = 1'b1;
      @(negedge clk);
      chk("R2", "addr held in T2", int'(uaddr_o), 0);
      trap_req_i = 1'b0;
      @(negedge clk);
      chk_mc("R7", 1, 3, 2);
   endtask

   task automatic t_reset_midrun();
      do_reset();
      step(); step();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_mc("R8", 0, 0, 0);
      step();
      chk_mc("R8", 0, 1, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sequential();
      t_cond_taken();
      t_cond_not_taken();
      t_trap();
      t_trap_window();
      t_reset_midrun();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule